// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

This block generates a pulse-width-modulated waveform from a 16-bit down counter. Software programs a period value and a high-time value into holding registers. It then arms the timer and starts it, either with a trigger bit in the control register or with a chosen edge on an external trigger line. Each period opens with the counter loaded from the period holding register. The output stays low until the count falls to the active high-time value, and it stays high from then until the counter wraps past zero.

The high-time holding register is copied into the active compare register only when the counter wraps. The period holding register is copied at the start and at every wrap. Software can therefore change either value at any moment without producing a malformed pulse. The timer runs continuously or stops after a single period. A trigger that arrives while the counter is running either restarts the period or is ignored, as software selects. Three event flags (trigger seen, high-time reached, wrap) each have an enable, and together they drive one interrupt line. The output can be forced low or inverted.

Top module: `pwm_timer`

## Requirements
- R1: Counting takes place only while control bit 0 (enable) is 1 and control field [14:12] (function) equals 3'b001. With any other function code, a trigger starts nothing, the output stays at its idle level and no trigger flag is raised.
- R2: Writing control bit 1 (software trigger, which reads back as 0) with enable set starts the counter. On the next clock edge the counter is loaded from the period register (address 2).
- R3: Control field [7:6] selects which edge of trig_in starts the timer: 00 none, 01 rising, 10 falling, 11 both. The edge is seen in the clock cycle in which trig_in changes, and the counter loads on the edge that ends that cycle.
- R4: While the timer runs, the output (before masking and inversion) is high exactly when the count is less than or equal to the active high-time value. A period lasts period+1 counter steps, so a high-time equal to the period gives an output that is high for the whole period.
- R5: The period register is copied into the counter at start and at each wrap (a step taken from count 0). The high-time register (address 3) reaches the active compare value only at a wrap, so a write takes effect from the following period and the value is 0 after reset.
- R6: Control bit 2 set to 1 selects single-period operation: the counter stops at the first wrap and the output returns to its idle level. When the bit is 0, periods repeat without end.
- R7: A write to control bit 2 is ignored while enable is already 1. It takes effect when enable is 0 before the write, including a write that sets enable.
- R8: With control bit 5 (restart) set to 1, a trigger that arrives while the counter runs reloads the counter and begins a fresh period. With the bit at 0, such a trigger does not change the count sequence.
- R9: Control field [11:8] (clock select) sets the number of clocks per counter step to 2^(2*code) for codes 0 to 2 and to 2^(code+4) for codes 3 and above (1, 4, 16, 128, 256, and so on).
- R10: Control bit 3 inverts the output level. Control bit 4 (mask) forces the output low whatever the inversion, period and high-time settings.
- R11: Status bits 0 (wrap), 1 (high-time reached) and 2 (trigger) are set by their events. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged. A read with bus_rmw high returns 1 in all three bits.
- R12: irq is high when any status flag is 1 and its enable is also 1 (status bit 4 for wrap, bit 5 for high-time, bit 6 for trigger).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 period, 3 high-time |
| bus_wdata | input | 16 | Write data |
| bus_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| trig_in | input | 1 | External start trigger, synchronous to clk |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Combined interrupt request |

## Verification
Nearly every error in the counter, the prescaler or the compare register shows on pwm_out. A wrong reload value, a high-time copied at the wrong moment or a wrong step rate moves an output edge within one period, so the bench predicts the level of pwm_out in every cycle of each window and finds such a fault within one period of its cause. Faults in the flags, the mode lock or the trigger gating show up in the next register read or on irq one cycle after the event. Several windows therefore span two or three periods so that buffer transfers at the wrap are also covered.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W = 16;
    localparam logic [2:0] FUNC_PWM = 3'b001;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_CYCLE = 2'd2,
        A_DUTY  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic       rsv;
        logic [2:0] func;
        logic [3:0] clk_sel;
        edge_sel_e  edge_sel;
        logic       restart;
        logic       mask;
        logic       invert;
        logic       one_shot;
        logic       sw_trig;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic trig;
        logic duty;
        logic uf;
    } evt_t;

    // log2 of clocks per counter step for a clock-select code
    function automatic logic [4:0] pre_shift(input logic [3:0] code);
        return (code < 4'd3) ? {code, 1'b0} : (5'(code) + 5'd4);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rmw_rd,
    output logic [DATA_W-1:0]   rdata,
    input  evt_t                evt,
    output ctrl_t               ctrl,
    output logic                sw_trig_q,
    output evt_t                flags,
    output evt_t                ie,
    output logic [CNT_W-1:0]    cycle_buf,
    output logic [CNT_W-1:0]    duty_buf
);

    ctrl_t ctrl_q, ctrl_nxt;
    evt_t  flags_q, ie_q, keep_mask;
    logic  wr_ctrl, wr_stat;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);

    always_comb begin
        ctrl_nxt         = ctrl_t'(wdata);
        ctrl_nxt.sw_trig = 1'b0;
        ctrl_nxt.rsv     = 1'b0;
        if (ctrl_q.enable)
            ctrl_nxt.one_shot = ctrl_q.one_shot;
    end

    assign keep_mask = wr_stat ? evt_t'(wdata[2:0]) : evt_t'(3'b111);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            sw_trig_q <= 1'b0;
            flags_q   <= '0;
            ie_q      <= '0;
            cycle_buf <= '0;
            duty_buf  <= '0;
        end else begin
            sw_trig_q <= wr_ctrl && wdata[1];
            flags_q   <= (flags_q & keep_mask) | evt;
            if (wr_ctrl)
                ctrl_q <= ctrl_nxt;
            if (wr_stat)
                ie_q <= evt_t'(wdata[6:4]);
            if (wr_en && (addr == A_CYCLE))
                cycle_buf <= wdata[CNT_W-1:0];
            if (wr_en && (addr == A_DUTY))
                duty_buf <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:  rdata = ctrl_q;
            A_STAT:  rdata = {9'd0, ie_q, 1'b0, (rmw_rd ? 3'b111 : flags_q)};
            A_CYCLE: rdata = DATA_W'(cycle_buf);
            default: rdata = DATA_W'(duty_buf);
        endcase
    end

    assign ctrl  = ctrl_q;
    assign flags = flags_q;
    assign ie    = ie_q;

    // R11
    uf_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.uf |=> flags_q.uf);

    // R7
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_q.enable) |=> (ctrl_q.one_shot == $past(ctrl_q.one_shot)));

endmodule

// File: rtl/pwm_trig_detect.sv
module pwm_trig_detect
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  edge_sel_e edge_sel,
    input  logic      trig_in,
    input  logic      sw_trig,
    output logic      trig_evt
);

    logic trig_q, rise, fall, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign rise = trig_in && !trig_q;
    assign fall = !trig_in && trig_q;

    always_comb begin
        case (edge_sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise || fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    assign trig_evt = enable && (sw_trig || edge_hit);

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [3:0] clk_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q, limit;

    assign limit = (PRE_W'(1) << pre_shift(clk_sel)) - PRE_W'(1);
    assign tick  = run && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || clr || tick) pre_q <= '0;
        else                            pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             one_shot,
    input  logic             restart_en,
    input  logic             trig_evt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cycle_buf,
    input  logic [CNT_W-1:0] duty_buf,
    output logic             accept,
    output logic             running,
    output logic             out_hi,
    output evt_t             evt
);

    logic             running_q, uf_evt, step;
    logic [CNT_W-1:0] cnt_q, duty_act, cnt_dec;

    assign accept  = en && trig_evt && (!running_q || restart_en);
    assign uf_evt  = en && running_q && tick && (cnt_q == '0) && !accept;
    assign step    = en && running_q && tick && (cnt_q != '0) && !accept;
    assign cnt_dec = cnt_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            duty_act  <= '0;
        end else if (!en) begin
            running_q <= 1'b0;
        end else if (accept) begin
            running_q <= 1'b1;
            cnt_q     <= cycle_buf;
        end else if (uf_evt) begin
            cnt_q    <= cycle_buf;
            duty_act <= duty_buf;
            if (one_shot) running_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_dec;
        end
    end

    assign evt.trig = trig_evt;
    assign evt.uf   = uf_evt;
    assign evt.duty = (accept && (cycle_buf == duty_act))
                   || (uf_evt && (cycle_buf == duty_buf))
                   || (step && (cnt_dec == duty_act));

    assign running = running_q;
    assign out_hi  = running_q && (cnt_q <= duty_act);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        uf_evt |=> (cnt_q == $past(cycle_buf)));

    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_act) |-> $past(uf_evt));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (uf_evt && one_shot) |=> !running_q);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (en && running_q && trig_evt && !restart_en && !uf_evt)
        |=> (cnt_q == $past(cnt_q) - CNT_W'($past(tick))));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_rmw,
    output logic [15:0] bus_rdata,
    input  logic        trig_in,
    output logic        pwm_out,
    output logic        irq
);

    ctrl_t            ctrl;
    evt_t             flags, ie, evt;
    logic             sw_trig_q, trig_evt, en_eff, tick, accept, running, out_hi;
    logic [CNT_W-1:0] cycle_buf, duty_buf;

    pwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rmw_rd(bus_rmw), .rdata(bus_rdata), .evt(evt), .ctrl(ctrl),
        .sw_trig_q(sw_trig_q), .flags(flags), .ie(ie),
        .cycle_buf(cycle_buf), .duty_buf(duty_buf)
    );

    assign en_eff = ctrl.enable && (ctrl.func == FUNC_PWM);

    pwm_trig_detect trig_i (
        .clk(clk), .rst(rst), .enable(en_eff), .edge_sel(ctrl.edge_sel),
        .trig_in(trig_in), .sw_trig(sw_trig_q), .trig_evt(trig_evt)
    );

    pwm_prescale #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst(rst), .run(running), .clr(accept),
        .clk_sel(ctrl.clk_sel), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .en(en_eff), .one_shot(ctrl.one_shot),
        .restart_en(ctrl.restart), .trig_evt(trig_evt), .tick(tick),
        .cycle_buf(cycle_buf), .duty_buf(duty_buf), .accept(accept),
        .running(running), .out_hi(out_hi), .evt(evt)
    );

    assign pwm_out = !ctrl.mask && (out_hi ^ ctrl.invert);
    assign irq     = |(flags & ie);

endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        bus_rmw = 1'b0;
    logic [15:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int act_duty = 0;

    always #5 clk = ~clk;

    pwm_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .pwm_out(pwm_out), .irq(irq)
    );

    function automatic logic [15:0] mk_ctrl(input bit en, trg, os, inv, msk, rs,
                                             input int edg, cks, fn);
        return {1'b0, 3'(fn), 4'(cks), 2'(edg), rs, msk, inv, os, trg, en};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_in = 1'b0; act_duty = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input bit m, output logic [15:0] d);
        bus_addr = a; bus_rmw = m;
        #1;
        d = bus_rdata;
        bus_rmw = 1'b0;
    endtask

    task automatic check_window(input int c, d, r, input bit os, inv,
                                input int k0, n, input string tag);
        int per, p, ph, cv, du;
        bit run, e;
        per = r * (c + 1);
        for (int k = k0; k < k0 + n; k++) begin
            @(negedge clk);
            p   = (k - 1) / per;
            ph  = ((k - 1) % per) / r;
            cv  = c - ph;
            du  = (p == 0) ? act_duty : d;
            run = !(os && p >= 1);
            e   = (run && cv <= du) ^ inv;
            chk(pwm_out === e, tag, pwm_out, e);
        end
        if ((k0 + n - 2) / per >= 1) act_duty = d;
    endtask

    task automatic check_level(input bit v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(pwm_out === v, tag, pwm_out, v);
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        chk(pwm_out === 1'b0, "R10 reset out", pwm_out, 0);
        chk(irq === 1'b0, "R12 reset irq", irq, 0);
        bus_read(2'd0, 1'b0, d);
        chk(d === 16'd0, "R1 reset ctrl", d, 0);
        bus_read(2'd1, 1'b0, d);
        chk(d === 16'd0, "R11 reset stat", d, 0);
    endtask

    task automatic t_func_gate();
        logic [15:0] d;
        do_reset();
        bus_write(2'd2, 16'd3);
        bus_write(2'd3, 16'd3);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 0));
        check_level(1'b0, 5, "R1 wrong function");
        bus_read(2'd1, 1'b0, d);
        chk(d[2] === 1'b0, "R1 no trig flag", d[2], 0);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        check_window(3, 3, 1, 0, 0, 1, 8, "R4 equal period and duty");
    endtask

    task automatic t_continuous();
        do_reset();
        bus_write(2'd2, 16'd5);
        bus_write(2'd3, 16'd2);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        check_window(5, 2, 1, 0, 0, 1, 18, "R2 R4 continuous");
        bus_write(2'd3, 16'd4);
        check_window(5, 2, 1, 0, 0, 20, 5, "R5 duty held until wrap");
        check_window(5, 4, 1, 0, 0, 25, 12, "R5 duty after wrap");
    endtask

    task automatic t_prescale();
        do_reset();
        bus_write(2'd2, 16'd2);
        bus_write(2'd3, 16'd1);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 1, 1));
        check_window(2, 1, 4, 0, 0, 1, 24, "R9 divide by 4");
        do_reset();
        bus_write(2'd2, 16'd1);
        bus_write(2'd3, 16'd0);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 2, 1));
        check_window(1, 0, 16, 0, 0, 1, 64, "R9 divide by 16");
    endtask

    task automatic t_oneshot();
        logic [15:0] d;
        do_reset();
        bus_write(2'd2, 16'd3);
        bus_write(2'd3, 16'd1);
        bus_write(2'd0, mk_ctrl(1, 1, 1, 0, 0, 0, 0, 0, 1));
        check_window(3, 1, 1, 1, 0, 1, 12, "R6 single period");
        bus_read(2'd0, 1'b0, d);
        chk(d[2] === 1'b1, "R6 mode readback", d[2], 1);
        chk(d[1] === 1'b0, "R2 trigger bit reads 0", d[1], 0);
        bus_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 1));
        bus_read(2'd0, 1'b0, d);
        chk(d[2] === 1'b1, "R7 mode locked while enabled", d[2], 1);
        bus_write(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0, 1));
        bus_write(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0, 1));
        bus_read(2'd0, 1'b0, d);
        chk(d[2] === 1'b0, "R7 mode written while disabled", d[2], 0);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        check_window(3, 1, 1, 0, 0, 1, 10, "R6 continuous after mode change");
    endtask

    task automatic t_restart();
        do_reset();
        bus_write(2'd2, 16'd7);
        bus_write(2'd3, 16'd3);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        check_window(7, 3, 1, 0, 0, 1, 3, "R8 before ignored trigger");
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        check_window(7, 3, 1, 0, 0, 5, 16, "R8 trigger ignored");
        do_reset();
        bus_write(2'd2, 16'd7);
        bus_write(2'd3, 16'd3);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 0, 0, 1));
        check_window(7, 3, 1, 0, 0, 1, 3, "R8 before restart");
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 0, 0, 1));
        check_window(7, 3, 1, 0, 0, 1, 10, "R8 restart reloads");
    endtask

    task automatic t_edges();
        logic [15:0] d;
        do_reset();
        bus_write(2'd2, 16'd2);
        bus_write(2'd3, 16'd2);
        bus_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 1, 0, 1));
        check_level(1'b0, 2, "R3 rising idle");
        trig_in = 1'b1;
        check_window(2, 2, 1, 0, 0, 1, 6, "R3 rising start");
        do_reset();
        bus_write(2'd2, 16'd2);
        bus_write(2'd3, 16'd2);
        bus_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 2, 0, 1));
        trig_in = 1'b1;
        check_level(1'b0, 4, "R3 falling ignores rise");
        trig_in = 1'b0;
        check_window(2, 2, 1, 0, 0, 1, 3, "R3 falling start");
        do_reset();
        bus_write(2'd2, 16'd2);
        bus_write(2'd3, 16'd2);
        bus_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 3, 0, 1));
        trig_in = 1'b1;
        check_window(2, 2, 1, 0, 0, 1, 2, "R3 both edges start");
        do_reset();
        bus_write(2'd2, 16'd2);
        bus_write(2'd3, 16'd2);
        bus_write(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0, 1));
        trig_in = 1'b1;
        check_level(1'b0, 3, "R3 none ignores rise");
        trig_in = 1'b0;
        check_level(1'b0, 3, "R3 none ignores fall");
        bus_read(2'd1, 1'b0, d);
        chk(d[2] === 1'b0, "R3 none no trig flag", d[2], 0);
    endtask

    task automatic t_output();
        do_reset();
        bus_write(2'd0, mk_ctrl(0, 0, 0, 1, 0, 0, 0, 0, 1));
        chk(pwm_out === 1'b1, "R10 inverted idle", pwm_out, 1);
        bus_write(2'd0, mk_ctrl(0, 0, 0, 1, 1, 0, 0, 0, 1));
        chk(pwm_out === 1'b0, "R10 mask over invert", pwm_out, 0);
        bus_write(2'd2, 16'd3);
        bus_write(2'd3, 16'd1);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0, 1));
        check_window(3, 1, 1, 0, 1, 1, 8, "R10 inverted run");
        bus_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 0, 1));
        check_level(1'b0, 6, "R10 masked run");
    endtask

    task automatic t_flags();
        logic [15:0] d;
        do_reset();
        bus_write(2'd2, 16'd1);
        bus_write(2'd3, 16'd0);
        bus_write(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0, 1));
        repeat (6) @(negedge clk);
        bus_write(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0, 1));
        bus_read(2'd1, 1'b0, d);
        chk(d[2:0] === 3'b111, "R11 all flags set", d[2:0], 7);
        bus_write(2'd1, 16'h0006);
        bus_read(2'd1, 1'b0, d);
        chk(d[2:0] === 3'b110, "R11 write 0 clears only that flag", d[2:0], 6);
        bus_read(2'd1, 1'b1, d);
        chk(d[2:0] === 3'b111, "R11 rmw read returns ones", d[2:0], 7);
        bus_read(2'd1, 1'b0, d);
        chk(d[2:0] === 3'b110, "R11 rmw read no side effect", d[2:0], 6);
        chk(irq === 1'b0, "R12 no enables", irq, 0);
        bus_write(2'd1, 16'h0016);
        chk(irq === 1'b0, "R12 wrap enable, wrap flag clear", irq, 0);
        bus_write(2'd1, 16'h0026);
        chk(irq === 1'b1, "R12 duty enable and flag", irq, 1);
        bus_write(2'd1, 16'h0020);
        chk(irq === 1'b0, "R12 flags cleared", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_func_gate();
        t_continuous();
        t_prescale();
        t_oneshot();
        t_restart();
        t_edges();
        t_output();
        t_flags();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule